// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a vector of level-sensitive interrupt request lines into one interrupt output for a processor. Each request line goes through a two-flop synchronizer. The synchronizer output forms the pending vector, so a pending bit is high while its line is high and low once the line drops. Nothing is latched, and software has no clear operation. A software-programmed enable mask selects which pending lines may raise the output. The output is a registered OR over the masked pending bits.

Software reaches the block over a plain 32-bit register bus with one shared address, a write strobe with data, and a read strobe. Every access completes in the cycle it is presented and the bus has no back-pressure. Read data appears one cycle after the read strobe. An error pulse marks any access the block does not decode, in the same cycle as that access. Two write-only addresses take writes and discard them. The number of request lines is a parameter from 1 to 32.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask and pending vectors are zero, `irq_out` is 0, `bus_rd_data` is 0 and `bus_err` is 0.
- R2: A write to address 0x04 loads the mask from `bus_wr_data`. A read of 0x04 returns the mask.
- R3: A read of address 0x0C returns the pending vector. Bit i of the pending vector equals `irq_in[i]` as sampled two clock edges earlier, and it clears when the line goes low, with no latching.
- R4: `irq_out` is registered. It is 1 in the cycle after one in which (mask AND pending) is nonzero, and 0 otherwise. A mask write therefore takes effect on `irq_out` one cycle after the write, and an input change takes effect three edges after it is applied.
- R5: Writes to addresses 0x00 and 0x14 raise no error and change neither the mask nor `irq_out`.
- R6: `bus_err` is 1 in the same cycle as a write to any address other than 0x00, 0x04 and 0x14, or as a read of any address other than 0x04 and 0x0C. Such a write changes no state.
- R7: `bus_rd_data` is registered. It carries the addressed value in the cycle after `bus_rd_en` and is 0 in the cycle after an invalid read or after a cycle with no read.
- R8: A read and a write to 0x04 in the same cycle return the mask value held before the write. The write still takes effect.
- R9: Mask and pending bits at positions N_IRQ and above always read as 0, whatever is written. The default N_IRQ is 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Level-sensitive request lines, asynchronous |
| bus_addr | input | ADDR_W | Byte address shared by reads and writes |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Read data, valid the cycle after the strobe |
| bus_err | output | 1 | One-cycle pulse on an undecoded access |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
Some functions can land in the same clock cycle:
- A software read of the mask and a software write of the mask. The bench issues both strobes to 0x04 together. It expects the old mask in the read data, and expects the new value on a read that follows.
- A mask write and a change on a request line. The bench sets a line and clears its enable together. It judges `irq_out` against the timing in R4.
- A valid read of 0x0C and an undecoded write to the same address. The bench checks that the error pulse and the read data appear together.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int unsigned BUS_W = 32;

  // Decoded register offsets
  localparam logic [7:0] OFS_LEVEL_NOP = 8'h00;
  localparam logic [7:0] OFS_ENABLE    = 8'h04;
  localparam logic [7:0] OFS_STATUS    = 8'h0C;
  localparam logic [7:0] OFS_CLEAR_NOP = 8'h14;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_ENABLE = 2'd1,
    RSEL_STATUS = 2'd2
  } rsel_e;

  typedef enum logic [1:0] {
    WSEL_NONE   = 2'd0,
    WSEL_ENABLE = 2'd1,
    WSEL_SINK   = 2'd2,
    WSEL_BAD    = 2'd3
  } wsel_e;

  // Mask of implemented line positions for a given line count
  function automatic logic [BUS_W-1:0] line_mask(input int unsigned n);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < BUS_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned N_IRQ = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        irq_in,
  output logic [lic_pkg::BUS_W-1:0] pend_o
);
  import lic_pkg::*;

  localparam int unsigned STAGES = 2;

  logic [N_IRQ-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= irq_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  generate
    if (N_IRQ < BUS_W) begin : g_pad
      assign pend_o = {{(BUS_W-N_IRQ){1'b0}}, stage_q[STAGES-1]};
    end else begin : g_full
      assign pend_o = stage_q[STAGES-1];
    end
  endgenerate

  // Count edges since reset so the level check only looks at sampled history
  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             settle_q <= '0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  // R3: pending follows input level two edges later
  assert_pend_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q >= 2'd2) |-> (pend_o[N_IRQ-1:0] == $past(irq_in, 2)));

endmodule

// File: rtl/lic_regs.sv
module lic_regs #(
  parameter int unsigned N_IRQ  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr_en,
  input  logic [lic_pkg::BUS_W-1:0] bus_wr_data,
  input  logic                      bus_rd_en,
  input  logic [lic_pkg::BUS_W-1:0] pend_i,
  output logic [lic_pkg::BUS_W-1:0] mask_o,
  output logic [lic_pkg::BUS_W-1:0] bus_rd_data,
  output logic                      bus_err
);
  import lic_pkg::*;

  localparam logic [BUS_W-1:0] LINE_M = line_mask(N_IRQ);

  rsel_e rsel;
  wsel_e wsel;
  logic [BUS_W-1:0] mask_q;
  logic [BUS_W-1:0] rd_q;
  logic [BUS_W-1:0] rd_val;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_ENABLE))      rsel = RSEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_STATUS)) rsel = RSEL_STATUS;
    else                                      rsel = RSEL_NONE;
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_ENABLE))         wsel = WSEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_LEVEL_NOP) ||
             bus_addr == ADDR_W'(OFS_CLEAR_NOP)) wsel = WSEL_SINK;
    else                                         wsel = WSEL_BAD;
  end

  always_comb begin
    unique case (rsel)
      RSEL_ENABLE: rd_val = mask_q;
      RSEL_STATUS: rd_val = pend_i & LINE_M;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (bus_wr_en && wsel == WSEL_ENABLE) begin
      mask_q <= bus_wr_data & LINE_M;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_q <= '0;
    else if (bus_rd_en) rd_q <= rd_val;
    else                rd_q <= '0;
  end

  assign bus_err = (bus_wr_en && wsel == WSEL_BAD) ||
                   (bus_rd_en && rsel == RSEL_NONE);
  assign mask_o      = mask_q;
  assign bus_rd_data = rd_q;

  // R5: sink writes leave the mask alone
  assert_sink_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !bus_err && bus_addr != ADDR_W'(OFS_ENABLE)) |=> $stable(mask_q));

  // R6: an undecoded write changes no state
  assert_bad_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_err && bus_addr != ADDR_W'(OFS_ENABLE)) |=> $stable(mask_q));

  // R7: an undecoded read yields zero data
  assert_bad_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !bus_wr_en && bus_err) |=> (bus_rd_data == '0));

  // R7: idle cycle yields zero data
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> (bus_rd_data == '0));

  // R9: unimplemented positions never reach the read data
  assert_high_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_data & ~LINE_M) == '0);

endmodule

// File: rtl/lic_combine.sv
module lic_combine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] pend_i,
  output logic         irq_o
);
  logic [W-1:0] hit;
  logic         irq_q;

  assign hit = mask_i & pend_i;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |hit;
  end

  assign irq_o = irq_q;

  // R4: no enabled line last cycle means no interrupt now
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_i == '0) |-> !irq_o);

  // R4: no pending line last cycle means no interrupt now
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_i == '0) |-> !irq_o);

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int unsigned N_IRQ  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IRQ-1:0]          irq_in,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr_en,
  input  logic [lic_pkg::BUS_W-1:0] bus_wr_data,
  input  logic                      bus_rd_en,
  output logic [lic_pkg::BUS_W-1:0] bus_rd_data,
  output logic                      bus_err,
  output logic                      irq_out
);
  import lic_pkg::*;

  initial begin
    assert_param_range_R9: assert (N_IRQ >= 1 && N_IRQ <= BUS_W && ADDR_W >= 5);
  end

  logic [BUS_W-1:0] pend;
  logic [BUS_W-1:0] mask;

  lic_sync #(.N_IRQ(N_IRQ)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_in),
    .pend_o (pend)
  );

  lic_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .pend_i      (pend),
    .mask_o      (mask),
    .bus_rd_data (bus_rd_data),
    .bus_err     (bus_err)
  );

  lic_combine #(.W(BUS_W)) u_combine (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask_i (mask),
    .pend_i (pend),
    .irq_o  (irq_out)
  );

  // R1: outputs quiet in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && bus_rd_data == '0));

endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int unsigned N = 24;
  localparam int unsigned AW = 8;
  localparam logic [31:0] LM = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [31:0]   bus_wr_data = '0;
  logic          bus_rd_en = 1'b0;
  logic [31:0]   bus_rd_data;
  logic          bus_err;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lvl_irq_ctrl #(.N_IRQ(N), .ADDR_W(AW)) u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .bus_err(bus_err), .irq_out(irq_out)
  );

  // mask written, line levels, expected irq_out
  typedef struct packed {
    logic [31:0] mask;
    logic [23:0] lines;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0001, 24'h000001, 1'b1},
    '{32'h0000_0001, 24'h000002, 1'b0},
    '{32'h00FF_0000, 24'h800000, 1'b1},
    '{32'h0000_0000, 24'hFFFFFF, 1'b0},
    '{32'hFFFF_FFFF, 24'h000000, 1'b0},
    '{32'hFF00_0000, 24'hFFFFFF, 1'b0},
    '{32'h00AA_AAAA, 24'h555555, 1'b0},
    '{32'h00AA_AAAA, 24'h555557, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr_en = 1'b1; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] old;
    cyc(3);
    // R1: reset state
    check("R1", "irq_out in reset", {31'd0, irq_out}, 32'd0);
    check("R1", "rd_data in reset", bus_rd_data, 32'd0);
    rst_n = 1'b1;
    cyc(1);
    check("R1", "err idle", {31'd0, bus_err}, 32'd0);
    rd(8'h04, d); check("R1", "mask after reset", d, 32'd0);
    rd(8'h0C, d); check("R1", "pending after reset", d, 32'd0);

    // Table walk: R2 R3 R4 R9
    for (int i = 0; i < 8; i++) begin
      wr(8'h04, VECS[i].mask);
      irq_in = VECS[i].lines;
      cyc(4);
      check("R4", $sformatf("vec %0d irq_out", i), {31'd0, irq_out}, {31'd0, VECS[i].exp_irq});
      rd(8'h04, d);
      check("R2", $sformatf("vec %0d mask readback (R9 high bits)", i), d, VECS[i].mask & LM);
      rd(8'h0C, d);
      check("R3", $sformatf("vec %0d pending", i), d, {8'd0, VECS[i].lines});
    end

    // R4 timing: mask write takes effect one cycle later
    irq_in = 24'h000010;
    wr(8'h04, 32'h0);
    cyc(3);
    check("R4", "masked line quiet", {31'd0, irq_out}, 32'd0);
    bus_addr = 8'h04; bus_wr_en = 1'b1; bus_wr_data = 32'h10;
    @(negedge clk); bus_wr_en = 1'b0;
    check("R4", "not yet after mask write edge", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R4", "one cycle after mask write", {31'd0, irq_out}, 32'd1);

    // R3: no latching, line drop clears pending and output
    irq_in = '0;
    @(negedge clk); @(negedge clk);
    check("R4", "two edges after drop still high", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R4", "three edges after drop", {31'd0, irq_out}, 32'd0);
    rd(8'h0C, d); check("R3", "pending cleared by level", d, 32'd0);

    // R5: sink addresses
    irq_in = 24'h000010;
    cyc(4);
    bus_addr = 8'h00; bus_wr_en = 1'b1; bus_wr_data = 32'h0;
    #1 check("R5", "no err at 0x00", {31'd0, bus_err}, 32'd0);
    @(negedge clk);
    bus_addr = 8'h14; bus_wr_data = 32'h0;
    #1 check("R5", "no err at 0x14", {31'd0, bus_err}, 32'd0);
    @(negedge clk); bus_wr_en = 1'b0;
    cyc(2);
    check("R5", "irq_out kept", {31'd0, irq_out}, 32'd1);
    rd(8'h04, d); check("R5", "mask kept", d, 32'h10);

    // R6: undecoded write
    bus_addr = 8'h08; bus_wr_en = 1'b1; bus_wr_data = 32'h0;
    #1 check("R6", "err on write 0x08", {31'd0, bus_err}, 32'd1);
    @(negedge clk); bus_wr_en = 1'b0;
    #1 check("R6", "err is a pulse", {31'd0, bus_err}, 32'd0);
    bus_addr = 8'h05; bus_wr_en = 1'b1; bus_wr_data = 32'h0;
    #1 check("R6", "err on misaligned write", {31'd0, bus_err}, 32'd1);
    @(negedge clk); bus_wr_en = 1'b0;
    cyc(1);
    rd(8'h04, d); check("R6", "mask unchanged", d, 32'h10);
    check("R6", "irq_out unchanged", {31'd0, irq_out}, 32'd1);

    // R6 R7: undecoded reads
    bus_addr = 8'h00; bus_rd_en = 1'b1;
    #1 check("R6", "err on read 0x00", {31'd0, bus_err}, 32'd1);
    @(negedge clk); bus_rd_en = 1'b0;
    check("R7", "bad read data", bus_rd_data, 32'd0);
    bus_addr = 8'h14; bus_rd_en = 1'b1;
    #1 check("R6", "err on read 0x14", {31'd0, bus_err}, 32'd1);
    @(negedge clk); bus_rd_en = 1'b0;
    check("R7", "bad read 0x14 data", bus_rd_data, 32'd0);
    @(negedge clk);
    check("R7", "idle read data", bus_rd_data, 32'd0);

    // Same cycle: valid read of 0x0C with bad write there
    bus_addr = 8'h0C; bus_rd_en = 1'b1; bus_wr_en = 1'b1; bus_wr_data = 32'hFFFF_FFFF;
    #1 check("R6", "err on write 0x0C", {31'd0, bus_err}, 32'd1);
    @(negedge clk); bus_rd_en = 1'b0; bus_wr_en = 1'b0;
    check("R3", "status read beside bad write", bus_rd_data, 32'h10);

    // R8: read and write the mask together
    rd(8'h04, old);
    bus_addr = 8'h04; bus_rd_en = 1'b1; bus_wr_en = 1'b1; bus_wr_data = 32'h0000_0300;
    @(negedge clk); bus_rd_en = 1'b0; bus_wr_en = 1'b0;
    check("R8", "old mask returned", bus_rd_data, old);
    rd(8'h04, d); check("R8", "new mask stored", d, 32'h0000_0300);

    // Same cycle: mask clear and line rise
    irq_in = '0;
    wr(8'h04, 32'h1);
    cyc(4);
    bus_addr = 8'h04; bus_wr_en = 1'b1; bus_wr_data = 32'h0;
    irq_in = 24'h000001;
    @(negedge clk); bus_wr_en = 1'b0;
    cyc(3);
    check("R4", "line rise with mask clear", {31'd0, irq_out}, 32'd0);

    // R1: reset clears state mid-run
    wr(8'h04, 32'h1);
    cyc(2);
    rst_n = 1'b0;
    cyc(2);
    irq_in = '0;
    rst_n = 1'b1;
    cyc(1);
    check("R1", "irq_out after reset", {31'd0, irq_out}, 32'd0);
    rd(8'h04, d); check("R1", "mask cleared by reset", d, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule